// File: doc/BRIEF.md
# Fixed Off-Time Bridge Current Chopper

This block sequences the drivers of one full bridge so that the load current is held near a peak limit. A synchronous over-current flag from an external comparator ends each conduction phase. The source driver is then switched off for a programmed number of cycles while the sink driver stays on, so the current recirculates and decays slowly. After that the source driver comes back on and the cycle repeats.

Every switching event restarts one shared blanking interval. The events are re-enable, the end of an off-time and the end of a direction-change dead-time. During blanking the comparator flag is ignored, which guarantees a minimum on-time after each source turn-on. A change on the direction input first forces both drivers off for a crossover delay, and only then does the new direction conduct. The off-time, blanking length and crossover length are cycle counts, loaded through a write strobe while the bridge is disabled.

Top module: `chop_ctrl`

## Requirements
- R1: After reset all five outputs are low and the lengths are off-time 64, blanking 8 and crossover 4 cycles.
- R2: The cycle after en_i is sampled low, src_on_o, snk_on_o, blank_o and off_state_o are all low. While the bridge is disabled, dir_o follows phase_i one cycle late.
- R3: The cycle after en_i is sampled high from the disabled state, a blanking window starts. It lasts exactly the blanking length, with src_on_o, snk_on_o and blank_o high.
- R4: When oc_i is sampled high in the conducting state (src_on_o high, blank_o low), the next cycle has src_on_o low, snk_on_o high and off_state_o high. This off-time lasts exactly the off-time length.
- R5: When an off-time ends, a blanking window of exactly the blanking length follows, with src_on_o and snk_on_o high.
- R6: oc_i high during a blanking window does not turn the source off. src_on_o stays high for the whole window.
- R7: If oc_i is still high when blanking ends, the block conducts for exactly one cycle and then enters a new off-time.
- R8: When phase_i differs from dir_o while enabled, the next cycle has src_on_o and snk_on_o low, blank_o high and dir_o equal to the new phase. This crossover lasts exactly the crossover length and is followed by a full blanking window.
- R9: A phase change during an off-time or a blanking window aborts that interval and starts the crossover on the next cycle.
- R10: cfg_we_i has an effect only while the bridge is disabled. A write while enabled leaves all lengths unchanged.
- R11: A programmed length of 0 behaves as a length of 1 cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| en_i | input | 1 | Bridge enable |
| phase_i | input | 1 | Requested current direction |
| oc_i | input | 1 | Synchronous over-current flag |
| cfg_we_i | input | 1 | Length write strobe (honoured while disabled) |
| cfg_off_i | input | OFF_W | Off-time length in cycles |
| cfg_blank_i | input | BLK_W | Blanking length in cycles |
| cfg_xover_i | input | XO_W | Crossover length in cycles |
| src_on_o | output | 1 | Source driver enable |
| snk_on_o | output | 1 | Sink driver enable |
| dir_o | output | 1 | Direction applied to the bridge |
| blank_o | output | 1 | Blanking or crossover active |
| off_state_o | output | 1 | Fixed off-time active |

## Verification
The bench measures every interval length in cycles across several length sets, including 1 and 0. A counter that is off by one would stretch or shorten each window, and a zero that wraps around would hang for the full counter range. It holds the over-current flag high through blanking: a design that honours trips too early would drop the source inside the window, and one that skips the minimum on-time would go straight from blanking into an off-time. It also flips the direction during an off-time and during blanking, and writes lengths while the bridge is enabled. Failing to abort would leave a driver conducting across a direction change, and an unguarded write would change the next blanking length.

// File: rtl/chop_pkg.sv
package chop_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_XOVER,
    ST_BLANK,
    ST_ON,
    ST_OFF
  } chop_state_e;

  function automatic int unsigned max3(int unsigned a, int unsigned b, int unsigned c);
    int unsigned m;
    m = (a > b) ? a : b;
    return (m > c) ? m : c;
  endfunction
endpackage

// File: rtl/chop_cfg.sv
module chop_cfg #(
  parameter int unsigned OFF_W   = 8,
  parameter int unsigned BLK_W   = 6,
  parameter int unsigned XO_W    = 4,
  parameter int unsigned OFF_DEF = 64,
  parameter int unsigned BLK_DEF = 8,
  parameter int unsigned XO_DEF  = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             idle_i,
  input  logic             we_i,
  input  logic [OFF_W-1:0] off_i,
  input  logic [BLK_W-1:0] blk_i,
  input  logic [XO_W-1:0]  xo_i,
  output logic [OFF_W-1:0] off_o,
  output logic [BLK_W-1:0] blk_o,
  output logic [XO_W-1:0]  xo_o
);
  logic [OFF_W-1:0] off_q;
  logic [BLK_W-1:0] blk_q;
  logic [XO_W-1:0]  xo_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      off_q <= OFF_W'(OFF_DEF);
      blk_q <= BLK_W'(BLK_DEF);
      xo_q  <= XO_W'(XO_DEF);
    end else if (idle_i && we_i) begin
      off_q <= off_i;
      blk_q <= blk_i;
      xo_q  <= xo_i;
    end
  end

  assign off_o = off_q;
  assign blk_o = blk_q;
  assign xo_o  = xo_q;

  // R10: lengths frozen while bridge runs
  p_cfg_hold_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !idle_i |=> ($stable(off_q) && $stable(blk_q) && $stable(xo_q)));
endmodule

// File: rtl/chop_timer.sv
module chop_timer #(
  parameter int unsigned CW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          load_i,
  input  logic [CW-1:0] len_i,
  output logic          done_o
);
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                cnt_q <= '0;
    else if (load_i)            cnt_q <= len_i;
    else if (cnt_q != '0)       cnt_q <= cnt_q - CW'(1);
  end

  // last cycle of an interval; length 0 behaves as 1
  assign done_o = (cnt_q <= CW'(1));
endmodule

// File: rtl/chop_seq.sv
module chop_seq
  import chop_pkg::*;
#(
  parameter int unsigned CW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          en_i,
  input  logic          phase_i,
  input  logic          oc_i,
  input  logic          done_i,
  input  logic [CW-1:0] off_len_i,
  input  logic [CW-1:0] blk_len_i,
  input  logic [CW-1:0] xo_len_i,
  output logic          load_o,
  output logic [CW-1:0] len_o,
  output logic          idle_o,
  output logic          src_on_o,
  output logic          snk_on_o,
  output logic          dir_o,
  output logic          blank_o,
  output logic          off_state_o
);
  chop_state_e state_q, state_d;
  logic        dir_q, dir_d;
  logic        flip;

  assign flip = (phase_i != dir_q);

  always_comb begin
    state_d = state_q;
    dir_d   = dir_q;
    load_o  = 1'b0;
    len_o   = blk_len_i;
    if (!en_i) begin
      state_d = ST_IDLE;
      dir_d   = phase_i;
    end else if (state_q == ST_IDLE) begin
      state_d = ST_BLANK;
      dir_d   = phase_i;
      load_o  = 1'b1;
    end else if (flip) begin
      // abort any interval, drivers off before new direction
      state_d = ST_XOVER;
      dir_d   = phase_i;
      load_o  = 1'b1;
      len_o   = xo_len_i;
    end else begin
      unique case (state_q)
        ST_XOVER: if (done_i) begin
          state_d = ST_BLANK;
          load_o  = 1'b1;
        end
        ST_BLANK: if (done_i) state_d = ST_ON;
        ST_ON: if (oc_i) begin
          state_d = ST_OFF;
          load_o  = 1'b1;
          len_o   = off_len_i;
        end
        ST_OFF: if (done_i) begin
          state_d = ST_BLANK;
          load_o  = 1'b1;
        end
        default: state_d = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      dir_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      dir_q   <= dir_d;
    end
  end

  assign idle_o      = (state_q == ST_IDLE);
  assign src_on_o    = (state_q == ST_BLANK) || (state_q == ST_ON);
  assign snk_on_o    = src_on_o || (state_q == ST_OFF);
  assign blank_o     = (state_q == ST_BLANK) || (state_q == ST_XOVER);
  assign off_state_o = (state_q == ST_OFF);
  assign dir_o       = dir_q;

  p_idle_off_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> (!src_on_o && !snk_on_o && !blank_o && !off_state_o));

  p_trip_off_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && state_q == ST_ON && !flip && oc_i) |=> (off_state_o && snk_on_o && !src_on_o));

  p_no_trip_in_blank_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && state_q == ST_BLANK && !flip) |=> src_on_o);

  p_flip_dead_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && !idle_o && flip) |=> (!src_on_o && !snk_on_o && blank_o));

  p_dir_change_dead_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dir_q != $past(dir_q)) |-> (!src_on_o && !snk_on_o));
endmodule

// File: rtl/chop_ctrl.sv
module chop_ctrl
  import chop_pkg::*;
#(
  parameter int unsigned OFF_W   = 8,
  parameter int unsigned BLK_W   = 6,
  parameter int unsigned XO_W    = 4,
  parameter int unsigned OFF_DEF = 64,
  parameter int unsigned BLK_DEF = 8,
  parameter int unsigned XO_DEF  = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic             phase_i,
  input  logic             oc_i,
  input  logic             cfg_we_i,
  input  logic [OFF_W-1:0] cfg_off_i,
  input  logic [BLK_W-1:0] cfg_blank_i,
  input  logic [XO_W-1:0]  cfg_xover_i,
  output logic             src_on_o,
  output logic             snk_on_o,
  output logic             dir_o,
  output logic             blank_o,
  output logic             off_state_o
);
  localparam int unsigned CW = max3(OFF_W, BLK_W, XO_W);

  logic [OFF_W-1:0] off_len;
  logic [BLK_W-1:0] blk_len;
  logic [XO_W-1:0]  xo_len;
  logic             idle, load, done;
  logic [CW-1:0]    len;

  chop_cfg #(
    .OFF_W(OFF_W), .BLK_W(BLK_W), .XO_W(XO_W),
    .OFF_DEF(OFF_DEF), .BLK_DEF(BLK_DEF), .XO_DEF(XO_DEF)
  ) u_cfg (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .idle_i(idle),
    .we_i  (cfg_we_i),
    .off_i (cfg_off_i),
    .blk_i (cfg_blank_i),
    .xo_i  (cfg_xover_i),
    .off_o (off_len),
    .blk_o (blk_len),
    .xo_o  (xo_len)
  );

  chop_timer #(.CW(CW)) u_timer (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .load_i(load),
    .len_i (len),
    .done_o(done)
  );

  chop_seq #(.CW(CW)) u_seq (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .en_i       (en_i),
    .phase_i    (phase_i),
    .oc_i       (oc_i),
    .done_i     (done),
    .off_len_i  (CW'(off_len)),
    .blk_len_i  (CW'(blk_len)),
    .xo_len_i   (CW'(xo_len)),
    .load_o     (load),
    .len_o      (len),
    .idle_o     (idle),
    .src_on_o   (src_on_o),
    .snk_on_o   (snk_on_o),
    .dir_o      (dir_o),
    .blank_o    (blank_o),
    .off_state_o(off_state_o)
  );
endmodule

// File: tb/chop_ctrl_tb_top.sv
module chop_ctrl_tb_top;
  logic       clk_i = 1'b0;
  logic       rst_ni, en_i, phase_i, oc_i, cfg_we_i;
  logic [7:0] cfg_off_i;
  logic [5:0] cfg_blank_i;
  logic [3:0] cfg_xover_i;
  logic       src_on_o, snk_on_o, dir_o, blank_o, off_state_o;

  int checks = 0;
  int fails  = 0;
  bit finished = 1'b0;

  always #2 clk_i = ~clk_i;

  chop_ctrl dut_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .en_i(en_i), .phase_i(phase_i), .oc_i(oc_i),
    .cfg_we_i(cfg_we_i), .cfg_off_i(cfg_off_i), .cfg_blank_i(cfg_blank_i),
    .cfg_xover_i(cfg_xover_i), .src_on_o(src_on_o), .snk_on_o(snk_on_o),
    .dir_o(dir_o), .blank_o(blank_o), .off_state_o(off_state_o)
  );

  localparam int VEC_N = 4;
  localparam int T_OFF [VEC_N] = '{10, 3, 1, 0};
  localparam int T_BLK [VEC_N] = '{5, 1, 12, 0};
  localparam int T_XO  [VEC_N] = '{2, 6, 1, 0};

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int eff(input int v);
    return (v == 0) ? 1 : v;
  endfunction

  // mode 0: off-time, 1: crossover, 2: blanking with source on
  task automatic count_win(input int mode, output int n);
    n = 0;
    while (n < 300 && ((mode == 0) ? off_state_o :
                       (mode == 1) ? (blank_o && !snk_on_o) :
                                     (blank_o && src_on_o))) begin
      n++;
      @(negedge clk_i);
    end
  endtask

  task automatic run_scn(input int f, input int b, input int x, input bit wr, input string tag);
    int n;
    en_i = 1'b0;
    @(negedge clk_i);
    @(negedge clk_i);
    if (wr) begin
      cfg_off_i = 8'(f); cfg_blank_i = 6'(b); cfg_xover_i = 4'(x);
      cfg_we_i = 1'b1;
      @(negedge clk_i);
      cfg_we_i = 1'b0;
    end
    en_i = 1'b1;
    @(negedge clk_i);
    check(src_on_o && snk_on_o && blank_o, {"R3 enable blank ", tag}, blank_o, 1);
    count_win(2, n);
    check(n == eff(b), {"R3 blank length ", tag}, n, eff(b));
    check(src_on_o && !blank_o && !off_state_o, {"R3 conducting ", tag}, src_on_o, 1);
    oc_i = 1'b1;
    @(negedge clk_i);
    oc_i = 1'b0;
    check(off_state_o && !src_on_o && snk_on_o, {"R4 trip ", tag}, off_state_o, 1);
    count_win(0, n);
    check(n == eff(f), {"R4 off length ", tag}, n, eff(f));
    count_win(2, n);
    check(n == eff(b), {"R5 blank after off ", tag}, n, eff(b));
    phase_i = ~phase_i;
    @(negedge clk_i);
    check(!src_on_o && !snk_on_o && blank_o && dir_o == phase_i,
          {"R8 crossover entry ", tag}, snk_on_o, 0);
    count_win(1, n);
    check(n == eff(x), {"R8 crossover length ", tag}, n, eff(x));
    count_win(2, n);
    check(n == eff(b), {"R8 blank after crossover ", tag}, n, eff(b));
  endtask

  initial begin
    #800000;
    if (!finished) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    int n;
    rst_ni = 1'b0; en_i = 1'b0; phase_i = 1'b0; oc_i = 1'b0; cfg_we_i = 1'b0;
    cfg_off_i = '0; cfg_blank_i = '0; cfg_xover_i = '0;
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    check(!src_on_o && !snk_on_o && !dir_o && !blank_o && !off_state_o,
          "R1 reset outputs", src_on_o | snk_on_o | blank_o | off_state_o, 0);

    // R1 defaults 64/8/4 without any write
    run_scn(64, 8, 4, 1'b0, "R1 defaults");
    for (int i = 0; i < VEC_N; i++)
      run_scn(T_OFF[i], T_BLK[i], T_XO[i], 1'b1, $sformatf("vec%0d R11", i));

    // R2 disable and idle direction tracking
    en_i = 1'b0;
    @(negedge clk_i);
    check(!src_on_o && !snk_on_o && !blank_o && !off_state_o, "R2 disable", snk_on_o, 0);
    phase_i = ~phase_i;
    @(negedge clk_i);
    check(dir_o == phase_i && !blank_o && !snk_on_o, "R2 idle dir follows", dir_o, phase_i);
    cfg_off_i = 8'd20; cfg_blank_i = 6'd6; cfg_xover_i = 4'd3;
    cfg_we_i = 1'b1;
    @(negedge clk_i);
    cfg_we_i = 1'b0;
    en_i = 1'b1;
    @(negedge clk_i);
    // R10 write while enabled
    cfg_off_i = 8'd2; cfg_blank_i = 6'd2; cfg_xover_i = 4'd1;
    cfg_we_i = 1'b1;
    @(negedge clk_i);
    cfg_we_i = 1'b0;
    count_win(2, n);
    check(n == 5, "R3 remaining blank", n, 5);
    en_i = 1'b0;
    @(negedge clk_i);
    check(!src_on_o && !snk_on_o && !blank_o, "R2 disable mid conduct", src_on_o, 0);
    @(negedge clk_i);
    en_i = 1'b1;
    @(negedge clk_i);
    oc_i = 1'b1;
    count_win(2, n);
    check(n == 6, "R6 R10 blank held under trip", n, 6);
    check(src_on_o && !blank_o && !off_state_o, "R7 one on cycle", src_on_o, 1);
    @(negedge clk_i);
    check(off_state_o && !src_on_o, "R7 new off-time", off_state_o, 1);
    oc_i = 1'b0;
    @(negedge clk_i);
    phase_i = ~phase_i;
    @(negedge clk_i);
    check(!off_state_o && !src_on_o && !snk_on_o && blank_o, "R9 abort off", off_state_o, 0);
    count_win(1, n);
    check(n == 3, "R9 crossover after off abort", n, 3);
    count_win(2, n);
    check(n == 6, "R8 blank after crossover", n, 6);
    oc_i = 1'b1;
    @(negedge clk_i);
    oc_i = 1'b0;
    count_win(0, n);
    check(n == 20, "R4 off length 20", n, 20);
    check(blank_o && src_on_o, "R5 blank entry", blank_o, 1);
    @(negedge clk_i);
    phase_i = ~phase_i;
    @(negedge clk_i);
    check(!src_on_o && !snk_on_o && blank_o && dir_o == phase_i, "R9 abort blank", src_on_o, 0);
    count_win(1, n);
    check(n == 3, "R9 crossover after blank abort", n, 3);
    count_win(2, n);
    check(n == 6, "R9 blank after crossover", n, 6);
    en_i = 1'b0;
    @(negedge clk_i);
    check(!src_on_o && !snk_on_o && !blank_o && !off_state_o, "R2 final disable", snk_on_o, 0);

    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule